// File: doc/BRIEF.md
# Accumulator Adder with Packed Status Flags

This block is the arithmetic and flag slice of a small 8-bit processor datapath. An add-with-carry unit and a load path produce the next accumulator value without registers. A registered 8-bit status byte holds the condition flags. The add takes its carry input from the stored carry flag. Every operation writes back the flags it is defined to touch, and leaves the other flags as they were.

The surrounding sequencer also uses the block for flag instructions. It can force any single flag to a chosen value. It can replace the whole status byte at once, as a pull from the stack does. The status byte is always visible on `status_o`, so the sequencer can push it as one byte.

Decimal addition is optional. It is built only when `DECIMAL_EN` is set, and it is active only while the decimal flag is 1.

Top module: `acc_alu_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `status_o` reads 0x20.
- R2: With `op_i` = 2'b01 (add), `acc_o` equals (acc_i + mem_i + C) mod 256. The carry flag (bit 0) is then loaded with bit 8 of that 9-bit sum.
- R3: On an add, the overflow flag (bit 6) is set when acc_i and mem_i have equal bit 7 and the binary sum's bit 7 differs from that of acc_i. Otherwise it is cleared.
- R4: On an add, the zero flag (bit 1) is set exactly when the 8-bit result is zero. The negative flag (bit 7) takes result bit 7.
- R5: With `op_i` = 2'b10 (load), `acc_o` equals mem_i. Only Z (bit 1) and N (bit 7) are updated, from mem_i. C, V, I, D and B keep their values.
- R6: Status bit 5 always reads 1, whatever is loaded or written into it.
- R7: When `flag_wr_i` is high, the flag at bit position `flag_sel_i` takes `flag_val_i` at the next edge. No other bit is changed by that request.
- R8: When `stat_ld_i` is high, the status byte becomes stat_din_i with bit 5 forced to 1. This overrides any add, load or single-flag request in the same cycle.
- R9: With `op_i` = 2'b00 or 2'b11, `acc_o` equals acc_i. With no other request, the status byte does not change.
- R10: With `DECIMAL_EN` = 0, the decimal flag (bit 3) has no effect on the add result or on any flag.
- R11: With `DECIMAL_EN` = 1 and the decimal flag set, each 4-bit digit is added with the carry from the digit below. A digit whose raw sum exceeds 9 is corrected by adding 6, keeping the low 4 bits, and it passes a carry to the next digit. C takes the carry out of the top digit. Z and N come from the corrected result. V follows the rule of R3 applied to the binary sum.
- R12: When a single-flag write and an add or load that updates the same bit happen in the same cycle, the single-flag write decides that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 2 | 00 none, 01 add, 10 load, 11 none |
| acc_i | input | DW | Current accumulator |
| mem_i | input | DW | Memory operand |
| flag_wr_i | input | 1 | Write a single flag |
| flag_sel_i | input | 3 | Bit position of the flag to write |
| flag_val_i | input | 1 | Value for the selected flag |
| stat_ld_i | input | 1 | Load the whole status byte |
| stat_din_i | input | 8 | Status byte to load |
| acc_o | output | DW | Next accumulator value |
| status_o | output | 8 | Packed status N V 1 B D I Z C, bit 7 down to bit 0 |

## Verification
The bench runs every pair of 8-bit add operands. The carry-in rotates naturally through the chain of adds, which catches two kinds of mistake: an overflow rule built from the carry instead of the operand signs, and a zero flag taken from the 9-bit sum, which would miss 0xFF + 0x01.

A second instance with decimal support runs beside the binary one while the decimal flag is set. A binary-only build that reacted to D would diverge from the arithmetic expected there. A wrong digit correction shows up at the 9-to-10 boundaries.

Load is swept with C and V preset, so a load that disturbs them is caught. The priority cases are also exercised: whole-byte load against a flag write, and a flag write against an add on the same bit. Writes to bit 5 are exercised too, since a design that stores that bit would let it read 0.

// File: rtl/acc_alu_pkg.sv
// Shared constants and types for the accumulator adder and status slice.
// Assumes the status byte is always 8 bits with a fixed flag layout.
package acc_alu_pkg;
    localparam int ST_W  = 8;
    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_I = 2;
    localparam int BIT_D = 3;
    localparam int BIT_B = 4;
    localparam int BIT_U = 5;
    localparam int BIT_V = 6;
    localparam int BIT_N = 7;

    localparam logic [ST_W-1:0] ST_RESET    = 8'h20;
    localparam logic [ST_W-1:0] ST_ONE_MASK = 8'h20;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_ADD  = 2'b01,
        OP_LOAD = 2'b10,
        OP_RSVD = 2'b11
    } alu_op_e;

    // Flag update request: mask selects bits, val gives their new values.
    typedef struct packed {
        logic [ST_W-1:0] mask;
        logic [ST_W-1:0] val;
    } st_upd_t;
endpackage

// File: rtl/acc_adder.sv
// Combinational add-with-carry over DW bits, binary or packed-digit decimal.
// Assumes DW is a multiple of 4. The decimal path exists in the netlist but
// is selected only when DECIMAL_EN is set and dec_i is high. Overflow is
// always taken from the binary sum.
module acc_adder #(
    parameter int DW         = 8,
    parameter bit DECIMAL_EN = 1'b0
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] m_i,
    input  logic          cin_i,
    input  logic          dec_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    localparam int NDIG = DW / 4;

    logic [DW:0]   bin_sum;
    logic [DW-1:0] bcd_sum;
    logic [NDIG:0] dcarry;
    logic          use_dec;

    // Plain binary sum including the carry input.
    assign bin_sum = {1'b0, a_i} + {1'b0, m_i} + {{DW{1'b0}}, cin_i};

    // Signed overflow: equal operand signs, result sign differs from a_i.
    assign ovf_o = ~(a_i[DW-1] ^ m_i[DW-1]) & (a_i[DW-1] ^ bin_sum[DW-1]);

    assign dcarry[0] = cin_i;

    // One digit adder per 4-bit group, corrected by 6 when above 9.
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [4:0] raw;
        logic       adj;
        assign raw = {1'b0, a_i[4*g +: 4]} + {1'b0, m_i[4*g +: 4]} + {4'b0, dcarry[g]};
        assign adj = (raw > 5'd9);
        assign bcd_sum[4*g +: 4] = raw[3:0] + (adj ? 4'd6 : 4'd0);
        assign dcarry[g+1] = adj;
    end

    assign use_dec = DECIMAL_EN & dec_i;

    // Pick the active result and carry.
    assign sum_o  = use_dec ? bcd_sum : bin_sum[DW-1:0];
    assign cout_o = use_dec ? dcarry[NDIG] : bin_sum[DW];
endmodule

// File: rtl/acc_flag_eval.sv
// Turns the operation and its result into a flag update request.
// Assumes res_i already holds the value that goes to the accumulator.
module acc_flag_eval
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] res_i,
    input  logic          cout_i,
    input  logic          ovf_i,
    output st_upd_t       upd_o
);
    // Select which flags the operation writes and their new values.
    always_comb begin
        upd_o = '0;
        case (op_i)
            OP_ADD: begin
                upd_o.mask[BIT_C] = 1'b1;
                upd_o.mask[BIT_V] = 1'b1;
                upd_o.mask[BIT_Z] = 1'b1;
                upd_o.mask[BIT_N] = 1'b1;
                upd_o.val[BIT_C]  = cout_i;
                upd_o.val[BIT_V]  = ovf_i;
                upd_o.val[BIT_Z]  = (res_i == '0);
                upd_o.val[BIT_N]  = res_i[DW-1];
            end
            OP_LOAD: begin
                upd_o.mask[BIT_Z] = 1'b1;
                upd_o.mask[BIT_N] = 1'b1;
                upd_o.val[BIT_Z]  = (res_i == '0);
                upd_o.val[BIT_N]  = res_i[DW-1];
            end
            default: upd_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_status_reg.sv
// Registered packed status byte with per-bit write priority:
// whole-byte load, then single-flag write, then operation update.
// Bit 5 is forced to 1 on the output, whatever its storage holds.
module acc_status_reg
    import acc_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_i,
    input  logic [ST_W-1:0] din_i,
    input  logic            fwr_i,
    input  logic [2:0]      fsel_i,
    input  logic            fval_i,
    input  st_upd_t         upd_i,
    output logic [ST_W-1:0] st_o
);
    logic [ST_W-1:0] st_q;

    // One flop per flag, each resolving its own write priority.
    for (genvar b = 0; b < ST_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[b] <= ST_RESET[b];
            else if (ld_i)
                st_q[b] <= din_i[b];
            else if (fwr_i && (fsel_i == 3'(b)))
                st_q[b] <= fval_i;
            else if (upd_i.mask[b])
                st_q[b] <= upd_i.val[b];
        end
    end

    // The unused bit always reads as one.
    assign st_o = st_q | ST_ONE_MASK;
endmodule

// File: rtl/acc_alu_status.sv
// Top of the accumulator adder and status slice. acc_o is combinational
// from the inputs and the stored flags; status_o changes on the clock.
// Assumes the sequencer holds inputs stable around the rising edge.
module acc_alu_status
    import acc_alu_pkg::*;
#(
    parameter int DW         = 8,
    parameter bit DECIMAL_EN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] mem_i,
    input  logic          flag_wr_i,
    input  logic [2:0]    flag_sel_i,
    input  logic          flag_val_i,
    input  logic          stat_ld_i,
    input  logic [7:0]    stat_din_i,
    output logic [DW-1:0] acc_o,
    output logic [7:0]    status_o
);
    alu_op_e       op;
    logic [DW-1:0] add_sum;
    logic          add_cout;
    logic          add_ovf;
    st_upd_t       upd;

    assign op = alu_op_e'(op_i);

    acc_adder #(.DW(DW), .DECIMAL_EN(DECIMAL_EN)) u_adder (
        .a_i    (acc_i),
        .m_i    (mem_i),
        .cin_i  (status_o[BIT_C]),
        .dec_i  (status_o[BIT_D]),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    // Choose the next accumulator value for the current operation.
    always_comb begin
        case (op)
            OP_ADD:  acc_o = add_sum;
            OP_LOAD: acc_o = mem_i;
            default: acc_o = acc_i;
        endcase
    end

    acc_flag_eval #(.DW(DW)) u_eval (
        .op_i   (op),
        .res_i  (acc_o),
        .cout_i (add_cout),
        .ovf_i  (add_ovf),
        .upd_o  (upd)
    );

    acc_status_reg u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (stat_ld_i),
        .din_i  (stat_din_i),
        .fwr_i  (flag_wr_i),
        .fsel_i (flag_sel_i),
        .fval_i (flag_val_i),
        .upd_i  (upd),
        .st_o   (status_o)
    );
endmodule

// File: rtl/acc_alu_status_chk.sv
// Property checker for acc_alu_status, attached with bind below.
module acc_alu_status_chk #(
    parameter int DW         = 8,
    parameter bit DECIMAL_EN = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] mem_i,
    input logic          flag_wr_i,
    input logic [2:0]    flag_sel_i,
    input logic          flag_val_i,
    input logic          stat_ld_i,
    input logic [7:0]    stat_din_i,
    input logic [DW-1:0] acc_o,
    input logic [7:0]    status_o
);
    logic [DW:0] sum9;
    logic        bare_add;
    logic        bare_load;
    logic        bare_idle;
    logic        bin_mode;

    assign sum9      = {1'b0, acc_i} + {1'b0, mem_i} + {{DW{1'b0}}, status_o[0]};
    assign bare_add  = (op_i == 2'b01) && !stat_ld_i && !flag_wr_i;
    assign bare_load = (op_i == 2'b10) && !stat_ld_i && !flag_wr_i;
    assign bare_idle = (op_i[0] == op_i[1]) && !stat_ld_i && !flag_wr_i;
    assign bin_mode  = !(DECIMAL_EN && status_o[3]);

    AST_U_HIGH: assert property (@(posedge clk) disable iff (!rst_n) status_o[5]); // R6
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (bare_add && bin_mode) |=> status_o[0] == $past(sum9[DW])); // R2
    AST_ADD_ZN: assert property (@(posedge clk) disable iff (!rst_n)
        bare_add |=> (status_o[1] == ($past(acc_o) == '0)) && (status_o[7] == $past(acc_o[DW-1]))); // R4
    AST_LOAD_ZN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bare_load |=> (status_o[1] == ($past(mem_i) == '0)) && (status_o[7] == $past(mem_i[DW-1]))
                      && (status_o[6:2] == $past(status_o[6:2])) && (status_o[0] == $past(status_o[0]))); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bare_idle |=> $stable(status_o)); // R9
    AST_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && !stat_ld_i && op_i == 2'b00)
        |=> ((status_o ^ $past(status_o)) & ~(8'h01 << $past(flag_sel_i))) == 8'h00); // R7
    AST_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && !stat_ld_i && flag_sel_i != 3'd5)
        |=> status_o[$past(flag_sel_i)] == $past(flag_val_i)); // R12
    AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_ld_i |=> status_o == ($past(stat_din_i) | 8'h20)); // R8
endmodule

bind acc_alu_status acc_alu_status_chk #(.DW(DW), .DECIMAL_EN(DECIMAL_EN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .acc_i      (acc_i),
    .mem_i      (mem_i),
    .flag_wr_i  (flag_wr_i),
    .flag_sel_i (flag_sel_i),
    .flag_val_i (flag_val_i),
    .stat_ld_i  (stat_ld_i),
    .stat_din_i (stat_din_i),
    .acc_o      (acc_o),
    .status_o   (status_o)
);

// File: tb/acc_alu_status_tb.sv
module acc_alu_status_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] op;
    logic [7:0] acc_in, mem_in, din;
    logic       fwr, fval, ld;
    logic [2:0] fsel;
    logic [7:0] acc_b, acc_d, st_b, st_d;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] ms_b, ms_d;

    always #2 clk = ~clk;

    acc_alu_status #(.DW(8), .DECIMAL_EN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc_in), .mem_i(mem_in),
        .flag_wr_i(fwr), .flag_sel_i(fsel), .flag_val_i(fval),
        .stat_ld_i(ld), .stat_din_i(din), .acc_o(acc_b), .status_o(st_b));

    acc_alu_status #(.DW(8), .DECIMAL_EN(1'b1)) u_dut_dec (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc_in), .mem_i(mem_in),
        .flag_wr_i(fwr), .flag_sel_i(fsel), .flag_val_i(fval),
        .stat_ld_i(ld), .stat_din_i(din), .acc_o(acc_d), .status_o(st_d));

    // Expected {acc, next status} from the requirements.
    function automatic logic [15:0] model(input bit dec_en, input logic [7:0] st,
            input logic [1:0] o, input logic [7:0] a, input logic [7:0] m,
            input logic fw, input logic [2:0] fs, input logic fv,
            input logic bl, input logic [7:0] bd);
        int s, lo, hi, hc;
        logic [7:0] res, acc, ns;
        logic c, v;
        s   = int'(a) + int'(m) + int'(st[0]);
        res = 8'(s);
        c   = (s > 255);
        v   = (a[7] == m[7]) && (res[7] != a[7]);
        if (dec_en && st[3]) begin
            lo = int'(a[3:0]) + int'(m[3:0]) + int'(st[0]);
            hc = 0;
            if (lo > 9) begin lo = lo + 6; hc = 1; end
            hi = int'(a[7:4]) + int'(m[7:4]) + hc;
            c  = 1'b0;
            if (hi > 9) begin hi = hi + 6; c = 1'b1; end
            res = 8'((hi % 16) * 16 + (lo % 16));
        end
        ns = st;
        case (o)
            2'b01: begin
                acc = res; ns[0] = c; ns[6] = v; ns[1] = (res == 8'h00); ns[7] = res[7];
            end
            2'b10: begin
                acc = m; ns[1] = (m == 8'h00); ns[7] = m[7];
            end
            default: acc = a;
        endcase
        if (fw) ns[fs] = fv;
        if (bl) ns = bd;
        ns[5] = 1'b1;
        return {acc, ns};
    endfunction

    task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [1:0] o, input logic [7:0] a, input logic [7:0] m,
            input logic fw, input logic [2:0] fs, input logic fv, input logic bl, input logic [7:0] bd);
        logic [15:0] rb, rd;
        @(negedge clk);
        op = o; acc_in = a; mem_in = m; fwr = fw; fsel = fs; fval = fv; ld = bl; din = bd;
        #1;
        rb = model(1'b0, ms_b, o, a, m, fw, fs, fv, bl, bd);
        rd = model(1'b1, ms_d, o, a, m, fw, fs, fv, bl, bd);
        check8(tag, "acc bin", acc_b, rb[15:8]);
        check8(tag, "acc dec", acc_d, rd[15:8]);
        @(posedge clk);
        #1;
        ms_b = rb[7:0];
        ms_d = rd[7:0];
        check8(tag, "status bin", st_b, ms_b);
        check8(tag, "status dec", st_d, ms_d);
    endtask

    task automatic add(input string tag, input logic [7:0] a, input logic [7:0] m);
        step(tag, 2'b01, a, m, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic setf(input string tag, input logic [2:0] fs, input logic fv);
        step(tag, 2'b00, 8'h5A, 8'hA5, 1'b1, fs, fv, 1'b0, 8'h00);
    endtask

    task automatic bload(input string tag, input logic [7:0] v);
        step(tag, 2'b00, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, v);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op = 2'b00; acc_in = 8'h00; mem_in = 8'h00;
        fwr = 1'b0; fsel = 3'd0; fval = 1'b0; ld = 1'b0; din = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check8("R1", "reset bin", st_b, 8'h20);
        check8("R1", "reset dec", st_d, 8'h20);
        ms_b = 8'h20;
        ms_d = 8'h20;
        @(negedge clk);
        rst_n = 1'b1;

        // R9: idle and reserved op codes pass acc_i and hold status
        step("R9", 2'b00, 8'h3C, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
        step("R9", 2'b11, 8'hC3, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);

        // R8 and R6: whole-byte loads of all zeros and all ones
        bload("R8_R6", 8'h00);
        bload("R8", 8'hFF);
        bload("R8", 8'h00);

        // R2 R3 R4: all operand pairs, carry chained from each previous add
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m++)
                add("R2_R3_R4", 8'(a), 8'(m));

        // R10 and R11: decimal flag set, digit-valued operands
        setf("R7", 3'd3, 1'b1);
        for (int i = 0; i < 100; i++)
            for (int j = 0; j < 100; j++)
                add("R10_R11", 8'((i / 10) * 16 + i % 10), 8'((j / 10) * 16 + j % 10));
        add("R10_R11", 8'h99, 8'h01);
        add("R10_R11", 8'h09, 8'h09);
        setf("R7", 3'd3, 1'b0);

        // R5: loads with C and V preset must leave them alone
        bload("R8", 8'h41);
        for (int m = 0; m < 256; m++)
            step("R5", 2'b10, 8'h77, 8'(m), 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
        bload("R8", 8'h1C);
        step("R5", 2'b10, 8'h01, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);

        // R7 and R6: each flag set then cleared, including the fixed bit
        for (int b = 0; b < 8; b++) begin
            setf("R7_R6", 3'(b), 1'b1);
            setf("R7_R6", 3'(b), 1'b0);
        end

        // R8: byte load beats an add and a flag write in the same cycle
        step("R8", 2'b01, 8'hFF, 8'h01, 1'b1, 3'd0, 1'b0, 1'b1, 8'h82);
        step("R8", 2'b10, 8'h00, 8'h00, 1'b1, 3'd7, 1'b1, 1'b1, 8'h00);

        // R12: flag write beats the add's update of the same bit
        bload("R8", 8'h00);
        step("R12", 2'b01, 8'hFF, 8'h01, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00);
        step("R12", 2'b01, 8'h01, 8'h01, 1'b1, 3'd1, 1'b1, 1'b0, 8'h00);
        step("R12", 2'b10, 8'h00, 8'h80, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule